// File: doc/BRIEF.md
# Indexed Clock Register Port

This block puts a 128-byte clock and configuration register space behind a two-address byte bus. A write to the even address loads a 7-bit index. A data access on the odd address then reads or writes the byte at that index. Each byte follows its own write rule:

- The time fields can ask the calendar to reload.
- Control byte A keeps its update-in-progress flag out of reach of the bus.
- Control byte B holds the hold-updates flag.
- Status byte C gathers interrupt requests and is cleared by a read.
- Status byte D is fixed.
- Every other byte is plain storage.

The calendar counter and the periodic timer sit outside the block and connect through side ports. The calendar copies time bytes in and gets a one-cycle reload pulse after a software time change. It also marks the start and end of its update window. The three interrupt sources each set their own flags in byte C. The block drives a level interrupt equal to the summary flag of byte C.

Byte map used throughout: seconds 0, minutes 2, hours 4, weekday 6, day 7, month 8, year 9. The alarm bytes are 1, 3 and 5. Control A is 10, control B is 11, status C is 12 and status D is 13.

Top module: `cmos_reg_port`

## Requirements
- R1: A bus write to the even address (bus_addr=0) stores bus_wdata[6:0] as the index; later odd-address data accesses use that index, so writing 0x8E selects byte 0x0E.
- R2: A bus read with bus_addr=0 returns 0xFF on bus_rdata.
- R3: A data write to byte 10 replaces bits 6..0 and leaves bit 7 (update-in-progress) at its current value.
- R4: A data write to byte 11 stores the whole byte; if bus_wdata[7] is 1 it also clears byte 10 bit 7 on the same edge, overriding upd_begin.
- R5: Data writes to bytes 12 and 13 leave them unchanged.
- R6: A data read of byte 12 returns its current value. On that edge byte 12 becomes just the flags set by requests in the same cycle, so with no request it becomes 0x00 and irq_o falls.
- R7: After reset, byte 10 is 0x26, byte 11 is 0x02, byte 12 is 0x00, byte 13 is 0x80, and every other byte, the index, irq_o and load_time_o are 0.
- R8: The set_periodic request ORs 0xC0 into byte 12, set_alarm ORs 0xA0, and set_update ORs 0x90. irq_o follows byte 12 bit 7, rises the cycle after a request and stays high until a read of byte 12.
- R9: load_time_o pulses for one cycle after either of two writes. The first is a data write to a time byte (0, 2, 4, 6, 7, 8 or 9) while byte 11 bit 7 is 0. The second is a write to byte 11 that moves its bit 7 from 1 to 0. No other write pulses it.
- R10: Alarm bytes 1, 3, 5 and bytes 14 to 127 read back the last value written.
- R11: upd_begin sets byte 10 bit 7 when byte 11 bit 7 is 0 and is ignored otherwise; upd_end clears it.
- R12: cal_wr writes cal_wdata into a time byte without a reload pulse. It is ignored for any other index, and a same-cycle bus data write to the same byte wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 1 | 0 index, 1 data |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data |
| cal_wr | input | 1 | Calendar writes a time byte |
| cal_idx | input | 7 | Calendar target byte |
| cal_wdata | input | 8 | Calendar data |
| upd_begin | input | 1 | Calendar update window starts |
| upd_end | input | 1 | Calendar update window ends |
| set_periodic | input | 1 | Periodic interrupt request |
| set_alarm | input | 1 | Alarm interrupt request |
| set_update | input | 1 | Update-ended interrupt request |
| reg_a_o | output | 8 | Byte 10 for the timer and calendar |
| reg_b_o | output | 8 | Byte 11 for the timer and calendar |
| load_time_o | output | 1 | Reload pulse to the calendar |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default reset constants for bytes 10, 11 and 13, so the reset check compares against 0x26, 0x02 and 0x80. With the index fixed at 7 bits, the top entry 0x7F and an index written with bit 7 set are both reachable and are exercised. Same-cycle collisions are driven on purpose: request against clearing read, calendar write against bus write, and the hold flag against upd_begin.

// File: rtl/cmos_reg_port.sv
module cmos_reg_port #(
  parameter logic [7:0] A_INIT = 8'h26,
  parameter logic [7:0] B_INIT = 8'h02,
  parameter logic [7:0] D_INIT = 8'h80,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic             bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             cal_wr,
  input  logic [IDX_W-1:0] cal_idx,
  input  logic [7:0]       cal_wdata,
  input  logic             upd_begin,
  input  logic             upd_end,
  input  logic             set_periodic,
  input  logic             set_alarm,
  input  logic             set_update,
  output logic [7:0]       reg_a_o,
  output logic [7:0]       reg_b_o,
  output logic             load_time_o,
  output logic             irq_o
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] IX_A = IDX_W'(10);
  localparam logic [IDX_W-1:0] IX_B = IDX_W'(11);
  localparam logic [IDX_W-1:0] IX_C = IDX_W'(12);
  localparam logic [IDX_W-1:0] IX_D = IDX_W'(13);

  logic [7:0]       regs [DEPTH];
  logic [IDX_W-1:0] idx;
  logic             load_q;

  function automatic logic is_time(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(0)) || (i == IDX_W'(2)) || (i == IDX_W'(4)) ||
           (i >= IDX_W'(6) && i <= IDX_W'(9));
  endfunction

  wire        wr_idx  = bus_sel & bus_wr & ~bus_addr;
  wire        wr_dat  = bus_sel & bus_wr & bus_addr;
  wire        rd_c    = bus_sel & ~bus_wr & bus_addr & (idx == IX_C);
  wire        any_set = set_periodic | set_alarm | set_update;
  wire [7:0]  set_bits = {any_set, set_periodic, set_alarm, set_update, 4'b0};
  wire [7:0]  c_reg   = regs[IX_C];
  wire        hold    = regs[IX_B][7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= 8'h00;
      regs[IX_A] <= A_INIT;
      regs[IX_B] <= B_INIT;
      regs[IX_D] <= D_INIT;
      idx    <= '0;
      load_q <= 1'b0;
    end else begin
      load_q <= 1'b0;
      if (cal_wr && is_time(cal_idx)) regs[cal_idx] <= cal_wdata;
      if (upd_begin && !hold) regs[IX_A][7] <= 1'b1;
      else if (upd_end)       regs[IX_A][7] <= 1'b0;
      if (rd_c) regs[IX_C] <= set_bits;
      else      regs[IX_C] <= c_reg | set_bits;
      if (wr_idx) idx <= bus_wdata[IDX_W-1:0];
      if (wr_dat) begin
        if (idx == IX_A) begin
          regs[IX_A][6:0] <= bus_wdata[6:0];
        end else if (idx == IX_B) begin
          regs[IX_B] <= bus_wdata;
          if (bus_wdata[7]) regs[IX_A][7] <= 1'b0;
          if (hold && !bus_wdata[7]) load_q <= 1'b1;
        end else if (idx != IX_C && idx != IX_D) begin
          regs[idx] <= bus_wdata;
          if (is_time(idx) && !hold) load_q <= 1'b1;
        end
      end
    end
  end

  assign bus_rdata   = bus_addr ? regs[idx] : 8'hFF;
  assign reg_a_o     = regs[IX_A];
  assign reg_b_o     = regs[IX_B];
  assign load_time_o = load_q;
  assign irq_o       = c_reg[7];
endmodule

module cmos_reg_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic       bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       upd_begin,
  input logic       upd_end,
  input logic       set_periodic,
  input logic       set_alarm,
  input logic       set_update,
  input logic [7:0] reg_a_o,
  input logic       load_time_o,
  input logic       irq_o,
  input logic [6:0] cur_idx,
  input logic [7:0] c_val
);
  wire any_set = set_periodic | set_alarm | set_update;
  wire dat_wr  = bus_sel && bus_wr && bus_addr;
  wire c_read  = bus_sel && !bus_wr && bus_addr && cur_idx == 7'd12;

  p_even_read_ff_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && !bus_addr) |-> bus_rdata == 8'hFF);
  p_uip_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && cur_idx == 7'd10 && !upd_begin && !upd_end) |=> reg_a_o[7] == $past(reg_a_o[7]));
  p_set_clears_uip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && cur_idx == 7'd11 && bus_wdata[7]) |=> !reg_a_o[7]);
  p_c_write_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && cur_idx == 7'd12 && !any_set) |=> $stable(c_val));
  p_c_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (c_read && !any_set) |=> (c_val == 8'h00 && !irq_o));
  p_set_raises_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    any_set |=> irq_o);
  p_irq_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !c_read) |=> irq_o);
  p_load_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_time_o |-> $past(dat_wr));
endmodule

bind cmos_reg_port cmos_reg_port_chk u_chk (.cur_idx(idx), .c_val(c_reg), .*);

// File: tb/sim_cmos_reg_port.sv
module sim_cmos_reg_port;
  localparam int CLK_NS = 10;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0, bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic cal_wr = 0;
  logic [6:0] cal_idx = 0;
  logic [7:0] cal_wdata = 0;
  logic upd_begin = 0, upd_end = 0;
  logic set_periodic = 0, set_alarm = 0, set_update = 0;
  logic [7:0] reg_a_o, reg_b_o;
  logic load_time_o, irq_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  cmos_reg_port u0 (.*);

  logic [7:0] m [128];
  logic [6:0] midx;
  logic       mload;

  function automatic bit tbyte(input int i);
    return i == 0 || i == 2 || i == 4 || (i >= 6 && i <= 9);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) m[i] = 8'h00;
      m[10] = 8'h26; m[11] = 8'h02; m[13] = 8'h80;
      midx = 0; mload = 0;
    end else begin
      logic [7:0] sb;
      sb = 0;
      if (set_periodic) sb = sb | 8'hC0;
      if (set_alarm)    sb = sb | 8'hA0;
      if (set_update)   sb = sb | 8'h90;
      mload = 0;
      if (cal_wr && tbyte(int'(cal_idx))) m[cal_idx] = cal_wdata;
      if (upd_begin && !m[11][7]) m[10][7] = 1'b1;
      else if (upd_end) m[10][7] = 1'b0;
      if (bus_sel && !bus_wr && bus_addr && midx == 12) m[12] = sb;
      else m[12] = m[12] | sb;
      if (bus_sel && bus_wr) begin
        if (!bus_addr) midx = bus_wdata[6:0];
        else if (midx == 10) m[10] = {m[10][7], bus_wdata[6:0]};
        else if (midx == 11) begin
          if (bus_wdata[7]) m[10][7] = 1'b0;
          if (m[11][7] && !bus_wdata[7]) mload = 1;
          m[11] = bus_wdata;
        end else if (midx != 12 && midx != 13) begin
          if (tbyte(int'(midx)) && !m[11][7]) mload = 1;
          m[midx] = bus_wdata;
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R10 model rdata", bus_rdata, bus_addr ? m[midx] : 8'hFF);
    chk("R8 model irq", irq_o, m[12][7]);
    chk("R3 model reg_a", reg_a_o, m[10]);
    chk("R4 model reg_b", reg_b_o, m[11]);
    chk("R9 model load", load_time_o, mload);
  end

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input string tag, input logic a, input logic [7:0] exp);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 chk(tag, bus_rdata, exp);
    tick();
    bus_sel = 0;
  endtask

  task automatic sel_rd(input string tag, input logic [6:0] i, input logic [7:0] exp);
    wr(0, {1'b0, i});
    rd(tag, 1, exp);
  endtask

  task automatic finish_run;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 100000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    // R7 reset
    chk("R7 irq", irq_o, 0);
    chk("R7 load", load_time_o, 0);
    sel_rd("R7 byte10", 10, 8'h26);
    sel_rd("R7 byte11", 11, 8'h02);
    sel_rd("R7 byte12", 12, 8'h00);
    sel_rd("R7 byte13", 13, 8'h80);
    sel_rd("R7 byte0", 0, 8'h00);
    // R2
    rd("R2 even read", 0, 8'hFF);
    // R1
    wr(0, 8'h8E); wr(1, 8'h5A);
    sel_rd("R1 index bit7 dropped", 14, 8'h5A);
    wr(0, 8'h7F); wr(1, 8'hC3);
    rd("R1 top index", 1, 8'hC3);
    // R10
    wr(0, 8'h03); wr(1, 8'h33);
    chk("R10 alarm no load", load_time_o, 0);
    rd("R10 alarm readback", 1, 8'h33);
    // R9 time write
    wr(0, 8'h00); wr(1, 8'h45);
    chk("R9 load pulse", load_time_o, 1);
    tick();
    chk("R9 load one cycle", load_time_o, 0);
    // R3 and R11
    wr(0, 8'h0A); wr(1, 8'h7F);
    chk("R3 uip stays 0", reg_a_o, 8'h7F);
    upd_begin = 1; tick(); upd_begin = 0;
    chk("R11 upd_begin", reg_a_o, 8'hFF);
    wr(1, 8'h20);
    chk("R3 uip kept 1", reg_a_o, 8'hA0);
    upd_end = 1; tick(); upd_end = 0;
    chk("R11 upd_end", reg_a_o, 8'h20);
    // R4
    upd_begin = 1; tick(); upd_begin = 0;
    wr(0, 8'h0B); wr(1, 8'h82);
    chk("R4 set clears uip", reg_a_o, 8'h20);
    chk("R4 b stored", reg_b_o, 8'h82);
    chk("R9 b set no load", load_time_o, 0);
    upd_begin = 1; tick(); upd_begin = 0;
    chk("R11 begin ignored in hold", reg_a_o, 8'h20);
    wr(0, 8'h02); wr(1, 8'h12);
    chk("R9 no load in hold", load_time_o, 0);
    wr(0, 8'h0B); wr(1, 8'h02);
    chk("R9 hold release load", load_time_o, 1);
    // R4 collision with upd_begin
    upd_begin = 1; wr(1, 8'h86); upd_begin = 0;
    chk("R4 beats upd_begin", reg_a_o, 8'h20);
    wr(1, 8'h02);
    // R5
    wr(0, 8'h0C); wr(1, 8'hFF);
    rd("R5 c unchanged", 1, 8'h00);
    wr(0, 8'h0D); wr(1, 8'h00);
    rd("R5 d unchanged", 1, 8'h80);
    // R8 and R6
    set_periodic = 1; tick(); set_periodic = 0;
    chk("R8 irq after periodic", irq_o, 1);
    set_alarm = 1; tick(); set_alarm = 0;
    tick();
    chk("R8 irq held", irq_o, 1);
    wr(0, 8'h0C);
    rd("R6 c value", 1, 8'hE0);
    chk("R6 irq released", irq_o, 0);
    rd("R6 c cleared", 1, 8'h00);
    set_update = 1; rd("R6 read with request", 1, 8'h00); set_update = 0;
    chk("R6 request survives read", irq_o, 1);
    rd("R8 update flags", 1, 8'h90);
    chk("R6 cleared again", irq_o, 0);
    // R12
    cal_wr = 1; cal_idx = 4; cal_wdata = 8'h23; tick(); cal_wr = 0;
    chk("R12 no load", load_time_o, 0);
    sel_rd("R12 cal write", 4, 8'h23);
    cal_wr = 1; cal_idx = 10; cal_wdata = 8'h00; tick(); cal_wr = 0;
    chk("R12 non-time ignored", reg_a_o, 8'h20);
    wr(0, 8'h06);
    cal_wr = 1; cal_idx = 6; cal_wdata = 8'h11; wr(1, 8'h05); cal_wr = 0;
    rd("R12 bus wins", 1, 8'h05);
    tick();
    finish_run();
  end
endmodule